// File: doc/BRIEF.md
# Byte-Synchronous Serial Transmitter with Frame Check Append

This block turns host-written characters into a continuous synchronous bit stream for a character-oriented synchronous link. The host writes characters through a two-address register port into a single-entry holding buffer. If the buffer still holds a character, the block stalls the host with a wait output. Each character is shifted onto the line least significant bit first. Every bit lasts a fixed number of clock cycles. When no message data is queued, the line carries a repeating sync character.

A 16-bit frame check value accumulates over the characters the host marks for inclusion. The mark is taken per character. The host arms an end-of-message latch once a message is under way. When the host then stops supplying characters, the block closes the frame by itself. It sends the two check bytes, then falls back to sync fill. Sending the check bytes sets the latch again, so each arming closes one frame only.

Top module: `bsync_tx`

## Requirements
- R1: During and right after reset, tx_line is 1, host_wait_n is 1, tx_empty is 1 and eom_sending is 0. The transmitter is disabled and the end-of-message latch is set (not armed).
- R2: While the enable bit (control bit 0) is 0, tx_line is held at 1. From the second clock edge after a control write clears the enable bit, the line is 1.
- R3: With the transmitter enabled and nothing to send, the line carries the sync character 8'h16 repeatedly, least significant bit first. Each bit lasts CLKS_PER_BIT cycles. The first character starts at the second clock edge after the control write that sets enable.
- R4: A data write (host_sel=0) while the buffer is empty is accepted at that clock edge. The character goes out at the next character boundary, and characters written fast enough follow one another without gaps.
- R5: A data write while the buffer is full drives host_wait_n low and leaves the buffer untouched. host_wait_n stays low for as long as the write is held and the buffer is full. The write is accepted at the first edge after the buffer empties.
- R6: A control write with bit 2 set clears the check value to 16'h0000. For each included character, the bits are taken LSB first, and each bit b updates the value c as c = (c >> 1) XOR (c[0] XOR b ? 16'hA001 : 0). This is the x^16+x^15+x^2+1 polynomial.
- R7: A character is included in the check value only if control bit 1 was 1 when that character was written to the data address.
- R8: A control write with bit 3 set arms the end-of-message latch. An armed latch plus an empty buffer at a character boundary after message data sends the check value's high byte, then its low byte, each LSB first, then sync characters.
- R9: Sending the check bytes sets the latch again. A later underrun with the latch set sends only sync characters.
- R10: eom_sending is 1 while either check byte is on the line and 0 while data or sync characters are.
- R11: tx_empty is 0 from the edge that accepts a data write until that character is moved into the shifter. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, held until host_wait_n is high |
| host_sel | input | 1 | 0 selects the data address, 1 the control address |
| host_wdata | input | 8 | Host write data |
| host_wait_n | output | 1 | Low while a data write is stalled on a full buffer |
| tx_line | output | 1 | Serial output, idles at 1 when disabled |
| tx_empty | output | 1 | Holding buffer is empty |
| eom_sending | output | 1 | Check bytes are being sent |

## Verification
The embedded properties assume the host behaves as a stalled bus cycle requires. A write blocked by host_wait_n keeps its strobe and data until the wait clears. The check-clear command is never issued in the same cycle as an included character moves into the shifter. The bench makes every host access from a task that starts at a falling edge. The data task holds its strobe while it watches host_wait_n. The check-clear command is issued only while sync fill is on the line and the buffer is empty, so it cannot meet a character load. The message table avoids the sync value, so the bench can find the first data character in the captured stream without ambiguity.

// File: rtl/bsync_pkg.sv
// Shared types and control-register bit positions for the byte-synchronous
// transmitter. Assumes an 8-bit host data path.
package bsync_pkg;

    // Kind of character currently loaded into the shifter
    typedef enum logic [1:0] {
        CH_SYNC   = 2'd0,
        CH_DATA   = 2'd1,
        CH_CRC_HI = 2'd2,
        CH_CRC_LO = 2'd3
    } char_kind_t;

    // Control-register bit positions (the host writes these)
    localparam int CTL_EN     = 0;
    localparam int CTL_CRC_IN = 1;
    localparam int CTL_CRCCLR = 2;
    localparam int CTL_EOMARM = 3;

endpackage

// File: rtl/bsync_host_if.sv
// Host register port: control register, single-entry transmit holding buffer,
// wait handshake and the end-of-message latch.
// Assumes a stalled host keeps host_wr and host_wdata steady until wait clears.
module bsync_host_if
    import bsync_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_sel,
    input  logic [DW-1:0] host_wdata,
    input  logic          take,
    input  logic          eom_set,
    output logic          wait_n,
    output logic          buf_full,
    output logic [DW-1:0] buf_data,
    output logic          buf_crc,
    output logic          tx_en,
    output logic          crc_clr,
    output logic          eom_latch
);

    logic crc_in_q;
    logic ctl_wr;
    logic dat_wr;

    assign ctl_wr = host_wr && host_sel;
    assign dat_wr = host_wr && !host_sel;

    // Stall a data write that finds the buffer occupied
    assign wait_n = !(dat_wr && buf_full);

    // Control register and one-cycle check-clear command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            crc_in_q <= 1'b0;
            crc_clr  <= 1'b0;
        end else begin
            crc_clr <= ctl_wr && host_wdata[CTL_CRCCLR];
            if (ctl_wr) begin
                tx_en    <= host_wdata[CTL_EN];
                crc_in_q <= host_wdata[CTL_CRC_IN];
            end
        end
    end

    // Holding buffer: fill on an accepted data write, drain on take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_data <= '0;
            buf_crc  <= 1'b0;
        end else if (take) begin
            buf_full <= 1'b0;
        end else if (dat_wr && !buf_full) begin
            buf_full <= 1'b1;
            buf_data <= host_wdata;
            buf_crc  <= crc_in_q;
        end
    end

    // End-of-message latch: set at reset and when check bytes start, host arms it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eom_latch <= 1'b1;
        end else if (eom_set) begin
            eom_latch <= 1'b1;
        end else if (ctl_wr && host_wdata[CTL_EOMARM]) begin
            eom_latch <= 1'b0;
        end
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && buf_full && !take) |=> (buf_full && $stable(buf_data))); // R5

endmodule

// File: rtl/bsync_crc16.sv
// Frame check accumulator: reflected CRC-16 (x^16+x^15+x^2+1), zero preset,
// updated a whole character per cycle, LSB of the character first.
// Assumes clr and upd are not requested in the same cycle; clr wins if they are.
module bsync_crc16 #(
    parameter int          DW   = 8,
    parameter int          CW   = 16,
    parameter logic [CW-1:0] POLY = 16'hA001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          upd,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] crc
);

    // Advance the check value over one character, LSB first
    function automatic logic [CW-1:0] step_char(input logic [CW-1:0] c_in,
                                                input logic [DW-1:0] d);
        logic [CW-1:0] c;
        logic          fb;
        c = c_in;
        for (int i = 0; i < DW; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    // Check register: clear on command, fold in included characters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (upd) begin
            crc <= step_char(crc, din);
        end
    end

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(crc)); // R6

    AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == '0)); // R6

endmodule

// File: rtl/bsync_shifter.sv
// Serial shifter with bit-period divider. Raises need at each character
// boundary (or when idle and enabled); the sequencer answers with load.
// Assumes load is only asserted while need is high.
module bsync_shifter #(
    parameter int DW           = 8,
    parameter int CLKS_PER_BIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          need,
    output logic          line
);

    localparam int DIVW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int BW   = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0]   shreg;
    logic [DIVW-1:0] divcnt;
    logic [BW-1:0]   bitcnt;
    logic            active;
    logic            last_div;
    logic            last_bit;

    assign last_div = (divcnt == DIVW'(CLKS_PER_BIT - 1));
    assign last_bit = (bitcnt == BW'(DW - 1));
    assign need     = en && (!active || (last_div && last_bit));
    assign line     = active ? shreg[0] : 1'b1;

    // Shift state: stop when disabled, load at boundaries, advance each bit period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '1;
            divcnt <= '0;
            bitcnt <= '0;
            active <= 1'b0;
        end else if (!en) begin
            active <= 1'b0;
            divcnt <= '0;
            bitcnt <= '0;
        end else if (load) begin
            shreg  <= load_data;
            divcnt <= '0;
            bitcnt <= '0;
            active <= 1'b1;
        end else if (active) begin
            if (last_div) begin
                divcnt <= '0;
                bitcnt <= bitcnt + 1'b1;
                shreg  <= shreg >> 1;
            end else begin
                divcnt <= divcnt + 1'b1;
            end
        end
    end

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> line); // R2

    AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> need); // R3

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && active && !last_div && !load) |=> $stable(shreg)); // R3

endmodule

// File: rtl/bsync_seq.sv
// Character sequencer: at each boundary picks pending check low byte, buffered
// data, check high byte on an armed underrun, or sync fill, in that priority.
// Assumes the shifter raises need once per character boundary.
module bsync_seq
    import bsync_pkg::*;
#(
    parameter int            DW        = 8,
    parameter int            CW        = 16,
    parameter logic [DW-1:0] SYNC_CHAR = 8'h16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          need,
    input  logic          buf_full,
    input  logic [DW-1:0] buf_data,
    input  logic          buf_crc,
    input  logic          eom_latch,
    input  logic [CW-1:0] crc,
    output logic          load,
    output logic [DW-1:0] load_data,
    output logic          take,
    output logic          crc_upd,
    output logic          eom_set,
    output logic          eom_sending
);

    char_kind_t    kind;
    char_kind_t    cur_kind;
    logic          msg_active;
    logic          lo_pending;
    logic [DW-1:0] lo_hold;

    // Choose the next character by priority
    always_comb begin
        if (lo_pending) begin
            kind      = CH_CRC_LO;
            load_data = lo_hold;
        end else if (buf_full) begin
            kind      = CH_DATA;
            load_data = buf_data;
        end else if (msg_active && !eom_latch) begin
            kind      = CH_CRC_HI;
            load_data = crc[CW-1 -: DW];
        end else begin
            kind      = CH_SYNC;
            load_data = SYNC_CHAR;
        end
    end

    assign load        = need;
    assign take        = need && (kind == CH_DATA);
    assign crc_upd     = take && buf_crc;
    assign eom_set     = need && (kind == CH_CRC_HI);
    assign eom_sending = en && ((cur_kind == CH_CRC_HI) || (cur_kind == CH_CRC_LO));

    // Frame state: message open, check low byte pending, kind on the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_active <= 1'b0;
            lo_pending <= 1'b0;
            lo_hold    <= '0;
            cur_kind   <= CH_SYNC;
        end else if (!en) begin
            msg_active <= 1'b0;
            lo_pending <= 1'b0;
            cur_kind   <= CH_SYNC;
        end else if (need) begin
            cur_kind   <= kind;
            lo_pending <= (kind == CH_CRC_HI);
            if (kind == CH_CRC_HI) begin
                lo_hold    <= crc[DW-1:0];
                msg_active <= 1'b0;
            end else if (kind == CH_DATA) begin
                msg_active <= 1'b1;
            end
        end
    end

    AST_EOM_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        eom_set |=> eom_latch); // R9

    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !buf_full); // R11

endmodule

// File: rtl/bsync_tx.sv
// Top: byte-synchronous transmitter with per-character check inclusion and
// automatic check-byte append on an armed underrun.
// Assumes a host that holds stalled writes until host_wait_n returns high.
module bsync_tx
    import bsync_pkg::*;
#(
    parameter int            DW           = 8,
    parameter int            CW           = 16,
    parameter int            CLKS_PER_BIT = 4,
    parameter logic [DW-1:0] SYNC_CHAR    = 8'h16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_sel,
    input  logic [DW-1:0] host_wdata,
    output logic          host_wait_n,
    output logic          tx_line,
    output logic          tx_empty,
    output logic          eom_sending
);

    logic          buf_full;
    logic [DW-1:0] buf_data;
    logic          buf_crc;
    logic          tx_en;
    logic          crc_clr;
    logic          eom_latch;
    logic          take;
    logic          eom_set;
    logic          crc_upd;
    logic [CW-1:0] crc;
    logic          need;
    logic          load;
    logic [DW-1:0] load_data;

    assign tx_empty = !buf_full;

    bsync_host_if #(.DW(DW)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_sel  (host_sel),
        .host_wdata(host_wdata),
        .take      (take),
        .eom_set   (eom_set),
        .wait_n    (host_wait_n),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .buf_crc   (buf_crc),
        .tx_en     (tx_en),
        .crc_clr   (crc_clr),
        .eom_latch (eom_latch)
    );

    bsync_crc16 #(.DW(DW), .CW(CW)) u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (crc_clr),
        .upd  (crc_upd),
        .din  (buf_data),
        .crc  (crc)
    );

    bsync_seq #(.DW(DW), .CW(CW), .SYNC_CHAR(SYNC_CHAR)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (tx_en),
        .need       (need),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .buf_crc    (buf_crc),
        .eom_latch  (eom_latch),
        .crc        (crc),
        .load       (load),
        .load_data  (load_data),
        .take       (take),
        .crc_upd    (crc_upd),
        .eom_set    (eom_set),
        .eom_sending(eom_sending)
    );

    bsync_shifter #(.DW(DW), .CLKS_PER_BIT(CLKS_PER_BIT)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .load     (load),
        .load_data(load_data),
        .need     (need),
        .line     (tx_line)
    );

    AST_WAIT_HOLDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wait_n && !take) |=> !tx_empty); // R5

endmodule

// File: tb/tb_bsync_tx.sv
module tb_bsync_tx;

    localparam int         CLK_PERIOD = 10;
    localparam int         CPB        = 4;
    localparam logic [7:0] SYNC       = 8'h16;
    localparam int         NMSG       = 6;
    // {include-in-check flag, data}
    localparam logic [8:0] MSG [0:NMSG-1] = '{
        {1'b1, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h77},
        {1'b1, 8'h01}, {1'b0, 8'hF0}, {1'b1, 8'h5A}
    };

    logic       clk;
    logic       rst_n;
    logic       host_wr;
    logic       host_sel;
    logic [7:0] host_wdata;
    logic       host_wait_n;
    logic       tx_line;
    logic       tx_empty;
    logic       eom_sending;

    int checks = 0;
    int errors = 0;

    logic [7:0] cap_d [0:255];
    logic       cap_e [0:255];
    int         cap_n = 0;
    bit         mon_go = 1'b0;

    bsync_tx #(.CLKS_PER_BIT(CPB), .SYNC_CHAR(SYNC)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_wait_n(host_wait_n),
        .tx_line    (tx_line),
        .tx_empty   (tx_empty),
        .eom_sending(eom_sending)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_crc(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ 16'hA001;
        end
        return c;
    endfunction

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_sel = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d, output int waited);
        @(negedge clk);
        host_wr = 1'b1; host_sel = 1'b0; host_wdata = d;
        waited = 0;
        #1;
        while (!host_wait_n) begin
            if (waited == 0) check_eq("R5", "tx_empty while stalled", int'(tx_empty), 0);
            waited++;
            @(negedge clk);
        end
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Line monitor: one sample per bit, eom_sending taken at bit 0
    initial begin
        wait (mon_go);
        @(posedge clk);
        @(posedge clk);
        forever begin
            logic [7:0] ch;
            logic       e;
            e = 1'b0;
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                ch[b] = tx_line;
                if (b == 0) e = eom_sending;
                repeat (CPB - 1) @(negedge clk);
            end
            if (cap_n < 256) begin
                cap_d[cap_n] = ch;
                cap_e[cap_n] = e;
                cap_n++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int          waited;
        int          total_wait;
        int          k;
        int          base;
        logic [15:0] exp_crc;

        rst_n = 1'b0; host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "tx_line in reset", int'(tx_line), 1);
        check_eq("R1", "host_wait_n in reset", int'(host_wait_n), 1);
        check_eq("R1", "tx_empty in reset", int'(tx_empty), 1);
        check_eq("R1", "eom_sending in reset", int'(eom_sending), 0);
        rst_n = 1'b1;

        // R2: disabled line stays marking
        waited = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!tx_line) waited++;
        end
        check_eq("R2", "low samples while disabled", waited, 0);

        // Enable with check inclusion and check clear; monitor aligns to this write
        @(negedge clk);
        host_wr = 1'b1; host_sel = 1'b1; host_wdata = 8'h07; mon_go = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        while (cap_n < 2) @(negedge clk);
        check_eq("R3", "first idle char", int'(cap_d[0]), int'(SYNC));
        check_eq("R3", "second idle char", int'(cap_d[1]), int'(SYNC));

        // Message from the table, arming end-of-message after the first write
        total_wait = 0;
        exp_crc    = 16'h0000;
        for (int i = 0; i < NMSG; i++) begin
            wr_ctrl({6'b0, MSG[i][8], 1'b1});
            wr_data(MSG[i][7:0], waited);
            total_wait += waited;
            if (MSG[i][8]) exp_crc = model_crc(exp_crc, MSG[i][7:0]);
            if (i == 0) begin
                check_eq("R11", "tx_empty after accepted write", int'(tx_empty), 0);
                wr_ctrl(8'h09);
            end
        end
        check_eq("R5", "writes stalled at least once", int'(total_wait > 0), 1);

        while (!tx_empty) @(negedge clk);
        repeat (CPB * 8 * 6) @(negedge clk);
        check_eq("R11", "tx_empty after drain", int'(tx_empty), 1);

        k = 0;
        while (k < cap_n && cap_d[k] == SYNC) k++;
        for (int i = 0; i < NMSG; i++)
            check_eq("R4", $sformatf("data char %0d", i), int'(cap_d[k + i]), int'(MSG[i][7:0]));
        check_eq("R8", "check high byte (R6 R7)", int'(cap_d[k + NMSG]), int'(exp_crc[15:8]));
        check_eq("R8", "check low byte (R6 R7)", int'(cap_d[k + NMSG + 1]), int'(exp_crc[7:0]));
        check_eq("R8", "sync after check", int'(cap_d[k + NMSG + 2]), int'(SYNC));
        check_eq("R9", "sync fill continues", int'(cap_d[k + NMSG + 3]), int'(SYNC));
        check_eq("R10", "eom_sending on last data", int'(cap_e[k + NMSG - 1]), 0);
        check_eq("R10", "eom_sending on high byte", int'(cap_e[k + NMSG]), 1);
        check_eq("R10", "eom_sending on low byte", int'(cap_e[k + NMSG + 1]), 1);
        check_eq("R10", "eom_sending on sync", int'(cap_e[k + NMSG + 2]), 0);

        // R9: latch was set by the check send, so a new underrun gives only sync
        wr_ctrl(8'h07);
        base = cap_n;
        wr_data(8'hC3, waited);
        while (cap_n < base + 6) @(negedge clk);
        k = base;
        while (k < cap_n && cap_d[k] == SYNC) k++;
        check_eq("R4", "unarmed message data", int'(cap_d[k]), 8'hC3);
        check_eq("R9", "no check after unarmed underrun", int'(cap_d[k + 1]), int'(SYNC));
        check_eq("R9", "sync continues unarmed", int'(cap_d[k + 2]), int'(SYNC));
        check_eq("R10", "eom_sending stays low unarmed", int'(cap_e[k + 1]), 0);

        // R2: disabling returns the line to marking
        wr_ctrl(8'h00);
        @(negedge clk);
        waited = 0;
        for (int i = 0; i < 3 * CPB * 8; i++) begin
            @(negedge clk);
            if (!tx_line) waited++;
        end
        check_eq("R2", "low samples after disable", waited, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule